// File: doc/BRIEF.md
# Buck Converter Startup and Enable Sequencer

This block decides, from power-up to regulation, which gate drivers of a synchronous buck converter may conduct. Analog comparators outside the block report six conditions as digital flags: input supply above its undervoltage level, boost rail healthy, current-limit calibration finished, compensation node above a logic-enable level, compensation node above a switching level, and feedback at the reference. The block also takes the modulator's high-side request. From these inputs it drives the high-side and low-side gate enables, a switch-node tri-state indication, the soft-start current enable, a reduced-current flag for the disabled state, a one-cycle soft-start discharge pulse and an open-loop or closed-loop mode flag.

Each comparator flag passes through a two-flop synchronizer before the state machine uses it. The machine moves through these states in order: reset, waiting for calibration, soft-start ramp with the node tri-stated, logic enabled but not switching, open-loop switching, and closed-loop switching. There is also a disabled state, in which the low-side switch clamps the output. A supply fault returns the machine to reset from any state and throws away the calibration.

Top module: `buck_start_seq`

## Requirements
- R1: During and after a synchronous reset (rst_n low), hs_en, ls_en, ss_src_en, ss_low_cur, ss_dump and closed_loop are 0 and sw_hiz is 1.
- R2: ss_src_en becomes 1 only after vin_ok and bst_ok are both high and, with the block waiting for calibration, cal_done goes from low to high. If cal_done is already high before that wait begins, it does not count.
- R3: Each comparator flag passes through two synchronizing flops. A change applied to a flag between clock edges shows at the outputs after the third rising edge, and not after the second.
- R4: While soft-start runs and the switching level has not yet been reached, hs_en and ls_en are 0 and sw_hiz is 1. This holds whether comp_lo is low or high.
- R5: Once comp_lo is high, a high comp_hi starts open-loop switching: hs_en equals pwm_req, ls_en equals its inverse, sw_hiz is 0, ss_src_en is 1 and closed_loop is 0. If comp_hi falls while comp_lo stays high, the gates return to off with the node tri-stated.
- R6: While switching, a high fb_ok sets closed_loop to 1 and clears ss_src_en. Switching continues with hs_en equal to pwm_req.
- R7: If comp_lo falls after logic has been enabled, the block enters the disabled state: hs_en 0, ls_en 1, sw_hiz 0, ss_src_en 1, ss_low_cur 1, closed_loop 0. When comp_lo rises again the gates return to off with the node tri-stated, and a following comp_hi resumes switching.
- R8: If vin_ok or bst_ok goes low in any state other than reset, the block returns to the R1 output state and pulses ss_dump high for exactly one cycle. Soft-start then needs a new cal_done rise.
- R9: hs_en and ls_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vin_ok | input | 1 | Input supply above its undervoltage level (asynchronous) |
| bst_ok | input | 1 | Boost rail healthy (asynchronous) |
| cal_done | input | 1 | Current-limit calibration finished (asynchronous) |
| comp_lo | input | 1 | Compensation node above the logic-enable level (asynchronous) |
| comp_hi | input | 1 | Compensation node above the switching level (asynchronous) |
| fb_ok | input | 1 | Feedback has reached the reference (asynchronous) |
| pwm_req | input | 1 | Modulator high-side request, same clock domain |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| sw_hiz | output | 1 | Switch node tri-stated (both gates off) |
| ss_src_en | output | 1 | Soft-start current source on |
| ss_low_cur | output | 1 | Soft-start source at reduced current (disabled state) |
| ss_dump | output | 1 | One-cycle soft-start discharge pulse on a supply fault |
| closed_loop | output | 1 | 1 in closed-loop regulation, 0 otherwise |

## Verification
The assertions check several rules on every cycle: the gates never overlap, the discharge pulse lasts one cycle and always arrives with the node tri-stated, a supply fault always reaches reset on the next edge, closed-loop mode is entered only when a synchronized reference flag is seen, and the reduced-current state is entered only after the logic-enable flag has dropped. Other behaviours only the bench scenarios can show. These are the exact three-edge synchronizer latency, the rule that a stale calibration flag is refused, the return path out of the disabled state, and the output values after a supply fault taken from each of the six non-reset states in turn.

// File: rtl/buck_seq_pkg.sv
// Package: state encoding and flag bit positions shared by the sequencer.
// Assumes: flags are gathered into one vector in the bit order below.
package buck_seq_pkg;
    localparam int FLAG_W  = 6;
    localparam int F_VIN   = 0;
    localparam int F_BST   = 1;
    localparam int F_CAL   = 2;
    localparam int F_LO    = 3;
    localparam int F_HI    = 4;
    localparam int F_FB    = 5;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_CAL    = 3'd1,
        ST_RAMP   = 3'd2,
        ST_LOGIC  = 3'd3,
        ST_OPEN   = 3'd4,
        ST_CLOSED = 3'd5,
        ST_DIS    = 3'd6
    } seq_state_t;
endpackage

// File: rtl/bss_sync.sv
// Module: multi-stage flop synchronizer for a vector of independent flags.
// Assumes: each bit is a quasi-static level; bits are not related to each other.
module bss_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Purpose: the first stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Purpose: each later stage settles the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bss_fsm.sv
// Module: sequencing state machine with the soft-start discharge pulse.
// Assumes: flags arrive already synchronized; cal completion is a rising level.
module bss_fsm
    import buck_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flg,
    output seq_state_t        state,
    output logic              ss_dump
);
    seq_state_t nxt;
    logic       cal_prev;
    logic       sup_ok;
    logic       cal_rise;

    assign sup_ok   = flg[F_VIN] & flg[F_BST];
    assign cal_rise = flg[F_CAL] & ~cal_prev;

    // Purpose: next-state selection; a supply fault overrides everything.
    always_comb begin
        nxt = state;
        if (!sup_ok) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF:   nxt = ST_CAL;
                ST_CAL:   if (cal_rise) nxt = ST_RAMP;
                ST_RAMP:  if (flg[F_LO]) nxt = ST_LOGIC;
                ST_LOGIC: begin
                    if (!flg[F_LO])     nxt = ST_DIS;
                    else if (flg[F_HI]) nxt = ST_OPEN;
                end
                ST_OPEN: begin
                    if (!flg[F_LO])      nxt = ST_DIS;
                    else if (!flg[F_HI]) nxt = ST_LOGIC;
                    else if (flg[F_FB])  nxt = ST_CLOSED;
                end
                ST_CLOSED: begin
                    if (!flg[F_LO])      nxt = ST_DIS;
                    else if (!flg[F_HI]) nxt = ST_LOGIC;
                end
                ST_DIS:   if (flg[F_LO]) nxt = ST_LOGIC;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // Purpose: state register, calibration edge memory and discharge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            cal_prev <= 1'b0;
            ss_dump  <= 1'b0;
        end else begin
            state    <= nxt;
            cal_prev <= flg[F_CAL];
            ss_dump  <= (state != ST_OFF) && !sup_ok;
        end
    end

    // R8: a supply fault always lands in reset on the next edge
    a_r8_fault_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(flg[F_VIN] && flg[F_BST]) |=> state == ST_OFF);
    // R6: closed loop is entered only with the reference flag seen
    a_r6_close_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSED && $past(state) != ST_CLOSED) |-> $past(flg[F_FB]));
    // R2: soft-start leaves calibration only after a seen completion
    a_r2_ramp_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && $past(state) == ST_CAL) |-> $past(flg[F_CAL]));
    // R7: the disabled state follows a dropped logic-enable flag
    a_r7_dis_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIS && $past(state) != ST_DIS) |-> !$past(flg[F_LO]));
endmodule

// File: rtl/bss_drive.sv
// Module: decodes sequencer state into gate enables and soft-start controls.
// Assumes: pwm_req is synchronous and only matters in the switching states.
module bss_drive
    import buck_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  logic       pwm_req,
    output logic       hs_en,
    output logic       ls_en,
    output logic       sw_hiz,
    output logic       ss_src_en,
    output logic       ss_low_cur,
    output logic       closed_loop
);
    // Purpose: per-state output decode.
    always_comb begin
        hs_en       = 1'b0;
        ls_en       = 1'b0;
        sw_hiz      = 1'b1;
        ss_src_en   = 1'b0;
        ss_low_cur  = 1'b0;
        closed_loop = 1'b0;
        case (state)
            ST_RAMP, ST_LOGIC: ss_src_en = 1'b1;
            ST_OPEN: begin
                hs_en     = pwm_req;
                ls_en     = ~pwm_req;
                sw_hiz    = 1'b0;
                ss_src_en = 1'b1;
            end
            ST_CLOSED: begin
                hs_en       = pwm_req;
                ls_en       = ~pwm_req;
                sw_hiz      = 1'b0;
                closed_loop = 1'b1;
            end
            ST_DIS: begin
                ls_en      = 1'b1;
                sw_hiz     = 1'b0;
                ss_src_en  = 1'b1;
                ss_low_cur = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: gate enables never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));
endmodule

// File: rtl/buck_start_seq.sv
// Module: top of the buck startup and enable sequencer.
// Assumes: comparator flags are asynchronous levels; pwm_req shares clk.
module buck_start_seq
    import buck_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_ok,
    input  logic bst_ok,
    input  logic cal_done,
    input  logic comp_lo,
    input  logic comp_hi,
    input  logic fb_ok,
    input  logic pwm_req,
    output logic hs_en,
    output logic ls_en,
    output logic sw_hiz,
    output logic ss_src_en,
    output logic ss_low_cur,
    output logic ss_dump,
    output logic closed_loop
);
    logic [FLAG_W-1:0] raw_flg;
    logic [FLAG_W-1:0] syn_flg;
    seq_state_t        state;

    always_comb begin
        raw_flg        = '0;
        raw_flg[F_VIN] = vin_ok;
        raw_flg[F_BST] = bst_ok;
        raw_flg[F_CAL] = cal_done;
        raw_flg[F_LO]  = comp_lo;
        raw_flg[F_HI]  = comp_hi;
        raw_flg[F_FB]  = fb_ok;
    end

    bss_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_flg), .q(syn_flg)
    );

    bss_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .flg(syn_flg), .state(state), .ss_dump(ss_dump)
    );

    bss_drive u_drive (
        .clk(clk), .rst_n(rst_n), .state(state), .pwm_req(pwm_req),
        .hs_en(hs_en), .ls_en(ls_en), .sw_hiz(sw_hiz), .ss_src_en(ss_src_en),
        .ss_low_cur(ss_low_cur), .closed_loop(closed_loop)
    );

    // R8: the discharge pulse lasts one cycle
    a_r8_dump_single: assert property (@(posedge clk) disable iff (!rst_n)
        ss_dump |=> !ss_dump);
    // R8: the discharge pulse coincides with a tri-stated node and gates off
    a_r8_dump_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        ss_dump |-> (sw_hiz && !hs_en && !ls_en && !ss_src_en));
endmodule

// File: tb/buck_start_seq_bench.sv
module buck_start_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_ok = 0, bst_ok = 0, cal_done = 0, comp_lo = 0, comp_hi = 0, fb_ok = 0, pwm_req = 0;
    logic hs_en, ls_en, sw_hiz, ss_src_en, ss_low_cur, ss_dump, closed_loop;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    buck_start_seq u_buck_start_seq (
        .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .bst_ok(bst_ok), .cal_done(cal_done),
        .comp_lo(comp_lo), .comp_hi(comp_hi), .fb_ok(fb_ok), .pwm_req(pwm_req),
        .hs_en(hs_en), .ls_en(ls_en), .sw_hiz(sw_hiz), .ss_src_en(ss_src_en),
        .ss_low_cur(ss_low_cur), .ss_dump(ss_dump), .closed_loop(closed_loop)
    );

    // wait n rising edges, then settle at the falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // compare the packed output vector {hs,ls,hiz,ss,low,dump,cl}
    task automatic chk(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {hs_en, ls_en, sw_hiz, ss_src_en, ss_low_cur, ss_dump, closed_loop};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual hs,ls,hiz,ss,low,dump,cl=%b expected %b", req, act, exp);
        end
    endtask

    localparam logic [6:0] O_OFF   = 7'b0010000;
    localparam logic [6:0] O_SS    = 7'b0011000;
    localparam logic [6:0] O_DIS   = 7'b0101100;
    localparam logic [6:0] O_DUMP  = 7'b0010010;

    function automatic logic [6:0] o_sw(input logic p, input logic cl);
        return {p, ~p, 1'b0, ~cl, 1'b0, 1'b0, cl};
    endfunction

    // drive up to a stage: 0 cal wait, 1 ramp, 2 logic, 3 open, 4 closed, 5 disabled
    task automatic go_stage(input int s);
        vin_ok = 1; bst_ok = 1; edges(4);
        if (s >= 1) begin cal_done = 1; edges(4); end
        if (s >= 2) begin comp_lo = 1; edges(4); end
        if (s >= 3) begin comp_hi = 1; edges(4); end
        if (s == 4) begin fb_ok = 1; edges(4); end
        if (s == 5) begin comp_lo = 0; comp_hi = 0; edges(4); end
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin @(posedge clk); wd++; end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(3);
        chk("R1 in reset", O_OFF);
        rst_n = 1;
        edges(2);
        chk("R1 after reset", O_OFF);

        // R2: stale calibration flag is not accepted
        cal_done = 1; edges(3);
        vin_ok = 1; bst_ok = 1; edges(8);
        chk("R2 stale cal ignored", O_OFF);
        cal_done = 0; edges(4);
        cal_done = 1;
        edges(2);
        chk("R3 no change after two edges", O_OFF);
        edges(1);
        chk("R3 change after third edge", O_SS);
        chk("R4 below logic level", O_SS);

        comp_lo = 1; edges(4);
        chk("R4 logic on not switching", O_SS);

        comp_hi = 1; edges(4);
        for (int p = 0; p < 2; p++) begin
            pwm_req = p[0]; #0.5;
            chk("R5 open loop switching", o_sw(p[0], 1'b0));
        end
        comp_hi = 0; edges(4);
        chk("R5 switching level lost", O_SS);
        comp_hi = 1; edges(4);

        fb_ok = 1; edges(4);
        for (int p = 0; p < 2; p++) begin
            pwm_req = p[0]; #0.5;
            chk("R6 closed loop", o_sw(p[0], 1'b1));
        end

        comp_lo = 0; comp_hi = 0; edges(4);
        chk("R7 disabled", O_DIS);
        comp_lo = 1; edges(4);
        chk("R7 re-enabled not switching", O_SS);
        comp_hi = 1; pwm_req = 1; edges(5);
        chk("R7 resumes switching", o_sw(1'b1, 1'b1));

        // R8 sweep: supply fault from every non-reset stage, alternating rails
        for (int s = 0; s < 6; s++) begin
            vin_ok = 0; bst_ok = 0; cal_done = 0; comp_lo = 0; comp_hi = 0; fb_ok = 0;
            edges(6);
            go_stage(s);
            if (s[0]) bst_ok = 0; else vin_ok = 0;
            edges(2);
            checks++;
            if (ss_dump !== 1'b0) begin
                errors++;
                $display("FAIL R8 stage %0d early dump actual %b expected 0", s, ss_dump);
            end
            edges(1);
            chk($sformatf("R8 fault stage %0d", s), O_DUMP);
            edges(1);
            chk($sformatf("R8 pulse end stage %0d", s), O_OFF);
            vin_ok = 1; bst_ok = 1; edges(8);
            chk($sformatf("R8 recal needed stage %0d", s), O_OFF);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule